// File: doc/BRIEF.md
# DC-Link Compensated Three-Phase PWM Modulator

This block turns three phase voltage references, given in absolute volts, into three complementary gate pairs driven by a center-aligned carrier. The DC-link voltage feeding the inverter can move over a wide range, and can step when the supply is swapped from one source to another. So each duty is renormalized against the link voltage measured for that carrier period rather than against a fixed modulation index. As a result, the fundamental voltage at the motor terminals follows the reference while the link voltage wanders.

At each carrier boundary the block latches the references and the link voltage. It subtracts a min-max common-mode offset from every phase, which widens the linear range by about 15%. A single restoring divider is shared by the three phases in turn. The new duty codes go into shadow registers and are applied at the following boundary. A link voltage under a configurable floor raises a fault flag and switches every gate off. Clamped duties raise a saturation flag.

Top module: `vdc_comp_pwm`

## Requirements
- R1: The carrier counts 0 up to 2^DUTY_W-1 and back down, so one period lasts 2*(2^DUTY_W-1) clocks and each period starts at count 0. A phase with duty code D is high on count values below D. Per period, the high-side gate is on for 2*D-1 clocks when D≥1 and for 0 clocks when D=0. The on-time is split around the period edges.
- R2: Within each pair, the low-side gate is the complement of the high-side gate while outputs are enabled. The two gates are never on together, and both are off while outputs are disabled.
- R3: Each phase uses x = 2*v - max(va,vb,vc) - min(va,vb,vc) and the latched link voltage V. If |x| < V, the code is 2^(DUTY_W-1) + floor(|x|*2^(DUTY_W-1)/V) for x ≥ 0, and 2^(DUTY_W-1) - floor(|x|*2^(DUTY_W-1)/V) for x < 0.
- R4: Identical references latched with two different link voltages produce different on-times.
- R5: References and link voltage are read only at the edge where the carrier sits at 0. Changes to these inputs at any other time have no effect on the outputs.
- R6: Values latched at one boundary take effect at the next boundary, for a full period.
- R7: If |x| ≥ V, the code clamps to 2^DUTY_W-1 when x > 0 and to 0 when x < 0. sat_o is high for the whole period in which any clamped code is applied, and low otherwise.
- R8: If the latched link voltage is below VDC_MIN, fault_o is high for the period that begins at that boundary. All six gates are off during that period and during the next one.
- R9: While reset is held, and for the first period after reset, all gates are off and both flags are low.
- R10: The three duty computations finish before the next carrier boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vref_a_i | input | REF_W | Phase a reference, signed, same LSB as the link voltage |
| vref_b_i | input | REF_W | Phase b reference, signed |
| vref_c_i | input | REF_W | Phase c reference, signed |
| vdc_i | input | VDC_W | Measured DC-link voltage, unsigned |
| gate_hi_o | output | 3 | High-side gates, bit 0 = a, bit 1 = b, bit 2 = c |
| gate_lo_o | output | 3 | Low-side gates, same bit order |
| sat_o | output | 1 | Some duty applied in this period was clamped |
| fault_o | output | 1 | Link voltage latched at the last boundary was below VDC_MIN |

## Verification
The assertions assume that reset is applied before any clock edge that matters. They also assume that DUTY_W is large enough for three serial divisions to fit inside one carrier period, which the completion property checks at every boundary. Stimulus changes the references and link voltage only at the falling clock edge. At mid-period it deliberately drives them to unrelated values, including a link voltage under the floor, so that sampling at any point other than the boundary would show up. Directed values cover the exact clamp threshold, the floor and one below it, a zero link voltage, and the full signed reference range. Random values mix linear, clamped and faulted periods.

// File: rtl/vdc_comp_pwm_pkg.sv
`timescale 1ns/1ps
package vdc_comp_pwm_pkg;
  localparam int NUM_PH = 3;

  typedef enum logic [1:0] {
    DIV_IDLE,
    DIV_LOAD,
    DIV_RUN,
    DIV_DONE
  } div_state_e;
endpackage

// File: rtl/cm_offset.sv
`timescale 1ns/1ps
module cm_offset
  import vdc_comp_pwm_pkg::*;
#(
  parameter int REF_W = 16
) (
  input  logic [NUM_PH-1:0][REF_W-1:0] ref_i,
  output logic [NUM_PH-1:0][REF_W+1:0] x2_o
);
  localparam int X_W = REF_W + 2;

  logic signed [REF_W-1:0] mx, mn;
  logic signed [X_W-1:0]   sum_mm;

  always_comb begin
    mx = $signed(ref_i[0]);
    mn = $signed(ref_i[0]);
    for (int i = 1; i < NUM_PH; i++) begin
      if ($signed(ref_i[i]) > mx) mx = $signed(ref_i[i]);
      if ($signed(ref_i[i]) < mn) mn = $signed(ref_i[i]);
    end
  end

  assign sum_mm = X_W'(mx) + X_W'(mn);

  // x2 = 2*(v + v_cm) with v_cm = -(max+min)/2, kept doubled to stay exact
  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    logic signed [X_W-1:0] v_ext;
    assign v_ext   = X_W'($signed(ref_i[g]));
    assign x2_o[g] = v_ext + v_ext - sum_mm;
  end
endmodule

// File: rtl/duty_divider.sv
`timescale 1ns/1ps
module duty_divider
  import vdc_comp_pwm_pkg::*;
#(
  parameter int X_W    = 18,
  parameter int VDC_W  = 16,
  parameter int DUTY_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [NUM_PH-1:0][X_W-1:0]       x2_i,
  input  logic [VDC_W-1:0]                 vdc_i,
  output logic [NUM_PH-1:0][DUTY_W-1:0]    duty_o,
  output logic                             sat_o,
  output logic                             busy_o,
  output logic                             done_o
);
  localparam int QB    = DUTY_W - 1;
  localparam int BC_W  = $clog2(QB + 1);
  localparam int CMP_W = (X_W > VDC_W) ? X_W : VDC_W;
  localparam logic [DUTY_W-1:0] HALF_C = DUTY_W'(1) << QB;
  localparam logic [DUTY_W-1:0] FULL_C = '1;

  div_state_e                       state_q;
  logic [1:0]                       ph_q;
  logic [BC_W-1:0]                  bcnt_q;
  logic [VDC_W-1:0]                 rem_q;
  logic [QB-1:0]                    quo_q;
  logic [NUM_PH-1:0][DUTY_W-1:0]    duty_q;
  logic                             sat_q;

  logic signed [X_W-1:0] cur;
  logic                  neg;
  logic [X_W-1:0]        mag_x;
  logic [CMP_W-1:0]      mag;
  logic                  over;
  logic [VDC_W:0]        r2, r_sub;
  logic                  ge;
  logic [VDC_W-1:0]      rem_nxt;
  logic [QB-1:0]         quo_nxt;
  logic [DUTY_W-1:0]     res_duty;
  logic                  last_ph;

  always_comb begin
    cur      = $signed(x2_i[ph_q]);
    neg      = cur[X_W-1];
    mag_x    = neg ? X_W'(-cur) : X_W'(cur);
    mag      = CMP_W'(mag_x);
    over     = mag >= CMP_W'(vdc_i);
    r2       = {rem_q, 1'b0};
    ge       = r2 >= {1'b0, vdc_i};
    r_sub    = r2 - {1'b0, vdc_i};
    rem_nxt  = ge ? r_sub[VDC_W-1:0] : r2[VDC_W-1:0];
    quo_nxt  = {quo_q[QB-2:0], ge};
    res_duty = neg ? (HALF_C - DUTY_W'(quo_nxt)) : (HALF_C + DUTY_W'(quo_nxt));
    last_ph  = (ph_q == 2'(NUM_PH - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      ph_q    <= '0;
      bcnt_q  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      duty_q  <= '0;
      sat_q   <= 1'b0;
    end else begin
      unique case (state_q)
        DIV_IDLE: if (start_i) begin
          ph_q    <= '0;
          sat_q   <= 1'b0;
          state_q <= DIV_LOAD;
        end
        DIV_LOAD: begin
          if (over) begin
            duty_q[ph_q] <= neg ? '0 : FULL_C;
            sat_q        <= 1'b1;
            if (last_ph) state_q <= DIV_DONE;
            else         ph_q    <= ph_q + 2'd1;
          end else begin
            rem_q   <= VDC_W'(mag);
            quo_q   <= '0;
            bcnt_q  <= '0;
            state_q <= DIV_RUN;
          end
        end
        DIV_RUN: begin
          rem_q  <= rem_nxt;
          quo_q  <= quo_nxt;
          bcnt_q <= bcnt_q + BC_W'(1);
          if (bcnt_q == BC_W'(QB - 1)) begin
            duty_q[ph_q] <= res_duty;
            if (last_ph) state_q <= DIV_DONE;
            else begin
              ph_q    <= ph_q + 2'd1;
              state_q <= DIV_LOAD;
            end
          end
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign duty_o = duty_q;
  assign sat_o  = sat_q;
  assign busy_o = (state_q != DIV_IDLE);
  assign done_o = (state_q == DIV_DONE);
endmodule

// File: rtl/pwm_carrier.sv
`timescale 1ns/1ps
module pwm_carrier #(
  parameter int CNT_W   = 12,
  parameter int CNT_MAX = 4095
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cnt_q == '0) begin
      cnt_q <= CNT_W'(1);
      up_q  <= 1'b1;
    end else if (up_q && cnt_q == CNT_W'(CNT_MAX)) begin
      cnt_q <= CNT_W'(CNT_MAX - 1);
      up_q  <= 1'b0;
    end else if (up_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/vdc_comp_pwm.sv
`timescale 1ns/1ps
module vdc_comp_pwm
  import vdc_comp_pwm_pkg::*;
#(
  parameter int REF_W   = 16,
  parameter int VDC_W   = 16,
  parameter int DUTY_W  = 12,
  parameter int VDC_MIN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REF_W-1:0] vref_a_i,
  input  logic [REF_W-1:0] vref_b_i,
  input  logic [REF_W-1:0] vref_c_i,
  input  logic [VDC_W-1:0] vdc_i,
  output logic [2:0]       gate_hi_o,
  output logic [2:0]       gate_lo_o,
  output logic             sat_o,
  output logic             fault_o
);
  localparam int X_W     = REF_W + 2;
  localparam int CNT_W   = DUTY_W;
  localparam int CNT_MAX = (1 << DUTY_W) - 1;

  logic [CNT_W-1:0]                carrier_cnt;
  logic                            boundary;
  logic [NUM_PH-1:0][REF_W-1:0]    smp_ref;
  logic [VDC_W-1:0]                smp_vdc;
  logic                            fault_q, start_q;
  logic [NUM_PH-1:0][X_W-1:0]      x2;
  logic [NUM_PH-1:0][DUTY_W-1:0]   div_duty, pend_duty, act_duty;
  logic                            div_sat, div_busy, div_done;
  logic                            pend_sat, pend_valid;
  logic                            act_sat, act_valid;
  logic                            gate_en;

  pwm_carrier #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) i_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (carrier_cnt),
    .zero_o (boundary)
  );

  cm_offset #(.REF_W(REF_W)) i_cm (
    .ref_i (smp_ref),
    .x2_o  (x2)
  );

  duty_divider #(.X_W(X_W), .VDC_W(VDC_W), .DUTY_W(DUTY_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q & ~fault_q),
    .x2_i    (x2),
    .vdc_i   (smp_vdc),
    .duty_o  (div_duty),
    .sat_o   (div_sat),
    .busy_o  (div_busy),
    .done_o  (div_done)
  );

  // input latch and shadow transfer, both at carrier zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_ref   <= '0;
      smp_vdc   <= '0;
      fault_q   <= 1'b0;
      start_q   <= 1'b0;
      act_duty  <= '0;
      act_sat   <= 1'b0;
      act_valid <= 1'b0;
    end else begin
      start_q <= boundary;
      if (boundary) begin
        smp_ref   <= {vref_c_i, vref_b_i, vref_a_i};
        smp_vdc   <= vdc_i;
        fault_q   <= (vdc_i < VDC_W'(VDC_MIN));
        act_duty  <= pend_duty;
        act_sat   <= pend_sat;
        act_valid <= pend_valid;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_duty  <= '0;
      pend_sat   <= 1'b0;
      pend_valid <= 1'b0;
    end else if (start_q && fault_q) begin
      pend_sat   <= 1'b0;
      pend_valid <= 1'b0;
    end else if (div_done) begin
      pend_duty  <= div_duty;
      pend_sat   <= div_sat;
      pend_valid <= 1'b1;
    end
  end

  assign gate_en = act_valid & ~fault_q;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_gate
    logic pwm_on;
    assign pwm_on       = (carrier_cnt < act_duty[g]);
    assign gate_hi_o[g] = gate_en & pwm_on;
    assign gate_lo_o[g] = gate_en & ~pwm_on;
  end

  assign sat_o   = act_sat;
  assign fault_o = fault_q;
endmodule

// File: rtl/vdc_comp_pwm_chk.sv
`timescale 1ns/1ps
module vdc_comp_pwm_chk #(
  parameter int CNT_W   = 12,
  parameter int CNT_MAX = 4095
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boundary_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [2:0]       gate_hi_i,
  input logic [2:0]       gate_lo_i,
  input logic             sat_i,
  input logic             fault_i
);
  assert_carrier_turn_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == CNT_W'(CNT_MAX) |=> cnt_i == CNT_W'(CNT_MAX - 1));

  assert_carrier_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> cnt_i == CNT_W'(1));

  assert_no_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_i & gate_lo_i) == 3'b000);

  assert_flags_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(sat_i) && $stable(fault_i));

  assert_fault_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (gate_hi_i == 3'b000) && (gate_lo_i == 3'b000));

  assert_fault_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_i) |-> (gate_hi_i == 3'b000) && (gate_lo_i == 3'b000));

  assert_div_in_time_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |-> !busy_i);
endmodule

bind vdc_comp_pwm vdc_comp_pwm_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary),
  .busy_i     (div_busy),
  .cnt_i      (carrier_cnt),
  .gate_hi_i  (gate_hi_o),
  .gate_lo_i  (gate_lo_o),
  .sat_i      (sat_o),
  .fault_i    (fault_o)
);

// File: tb/test_vdc_comp_pwm.sv
`timescale 1ns/1ps
module test_vdc_comp_pwm;
  localparam int DW   = 8;
  localparam int VMIN = 64;
  localparam int M    = (1 << DW) - 1;
  localparam int PER  = 2 * M;
  localparam int HALF = 1 << (DW - 1);
  localparam int NP   = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] va, vb, vc, vdc;
  logic [2:0]  ghi, glo;
  logic        sat, flt;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  int sa [NP], sb [NP], sc [NP], sv [NP];
  bit ef [NP], es [NP];
  int ed [NP][3];
  int ontime_a [NP];

  always #2.5 clk = ~clk;

  vdc_comp_pwm #(.REF_W(16), .VDC_W(16), .DUTY_W(DW), .VDC_MIN(VMIN)) i_vdc_comp_pwm (
    .clk_i(clk), .rst_ni(rst_n),
    .vref_a_i(va), .vref_b_i(vb), .vref_c_i(vc), .vdc_i(vdc),
    .gate_hi_o(ghi), .gate_lo_o(glo), .sat_o(sat), .fault_o(flt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int calc_duty(input int v, input int mx, input int mn,
                                   input int vd, output bit s);
    int x2, mag;
    longint q;
    x2  = 2 * v - mx - mn;
    mag = (x2 < 0) ? -x2 : x2;
    s   = 1'b0;
    if (mag >= vd) begin
      s = 1'b1;
      return (x2 > 0) ? M : 0;
    end
    q = (longint'(mag) << (DW - 1)) / vd;
    return (x2 < 0) ? HALF - int'(q) : HALF + int'(q);
  endfunction

  task automatic prepare();
    int mx, mn;
    bit s0, s1, s2;
    for (int p = 0; p < NP; p++) begin
      mx = sa[p]; if (sb[p] > mx) mx = sb[p]; if (sc[p] > mx) mx = sc[p];
      mn = sa[p]; if (sb[p] < mn) mn = sb[p]; if (sc[p] < mn) mn = sc[p];
      ef[p] = (sv[p] < VMIN);
      if (ef[p]) begin
        ed[p][0] = 0; ed[p][1] = 0; ed[p][2] = 0; es[p] = 1'b0;
      end else begin
        ed[p][0] = calc_duty(sa[p], mx, mn, sv[p], s0);
        ed[p][1] = calc_duty(sb[p], mx, mn, sv[p], s1);
        ed[p][2] = calc_duty(sc[p], mx, mn, sv[p], s2);
        es[p] = s0 | s1 | s2;
      end
    end
  endtask

  task automatic set_stim(input int p, input int a, input int b, input int c, input int d);
    sa[p] = a; sb[p] = b; sc[p] = c; sv[p] = d;
  endtask

  initial begin
    void'($urandom(32'd2024));
    set_stim(0, 0, 0, 0, 400);
    set_stim(1, 100, -50, -50, 400);
    set_stim(2, 100, -50, -50, 800);
    set_stim(3, 100, -100, 0, 200);
    set_stim(4, 100, -100, 0, 201);
    set_stim(5, 10, 0, -10, VMIN - 1);
    set_stim(6, 10, 0, -10, VMIN);
    set_stim(7, 300, -200, 50, 1000);
    set_stim(8, 500, 0, -500, 0);
    set_stim(9, 0, 0, 0, 500);
    set_stim(10, -32768, 32767, 0, 65535);
    set_stim(11, -40, 25, 15, 90);
    for (int p = 12; p < NP; p++)
      set_stim(p, int'($urandom_range(6000)) - 3000, int'($urandom_range(6000)) - 3000,
               int'($urandom_range(6000)) - 3000, 40 + int'($urandom_range(7960)));
    prepare();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    va = '0; vb = '0; vc = '0; vdc = '0;
    repeat (4) @(negedge clk);
    // R9: outputs while reset is held
    chk("R9 gates in reset", int'({ghi, glo}), 0);
    chk("R9 flags in reset", int'({sat, flt}), 0);
    rst_n = 1'b1;
    for (int p = 0; p < NP; p++) begin
      int hi_n [3];
      int lo_n [3];
      int ovl, fbad, sbad, first_a, last_a;
      bit off, exp_sat;
      string tag;
      va = 16'(sa[p]); vb = 16'(sb[p]); vc = 16'(sc[p]); vdc = 16'(sv[p]);
      hi_n = '{0, 0, 0}; lo_n = '{0, 0, 0};
      ovl = 0; fbad = 0; sbad = 0; first_a = 0; last_a = 0;
      off = (p == 0) || ef[p] || ef[p-1 < 0 ? 0 : p-1];
      exp_sat = (p > 0 && !ef[p-1]) ? es[p-1] : 1'b0;
      for (int j = 0; j < PER; j++) begin
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          hi_n[k] += int'(ghi[k]);
          lo_n[k] += int'(glo[k]);
        end
        if ((ghi & glo) != 3'b000) ovl++;
        if (flt != ef[p]) fbad++;
        if (sat != exp_sat) sbad++;
        if (j == 0) first_a = int'(ghi[0]);
        if (j == PER - 1) last_a = int'(ghi[0]);
        if (j == M) begin
          // R5: mid-period junk on every sampled input
          va = 16'($urandom); vb = 16'($urandom); vc = 16'($urandom);
          vdc = 16'($urandom_range(VMIN - 1));
        end
      end
      ontime_a[p] = hi_n[0];
      if (p == 0) tag = "R9";
      else if (off) tag = "R8";
      else if (es[p-1]) tag = "R7";
      else tag = "R3 R5 R6 R10";
      for (int k = 0; k < 3; k++) begin
        int exp_hi;
        exp_hi = off ? 0 : ((ed[p-1 < 0 ? 0 : p-1][k] == 0) ? 0 : 2 * ed[p-1 < 0 ? 0 : p-1][k] - 1);
        chk($sformatf("%s hi on-time p%0d ph%0d", tag, p, k), hi_n[k], exp_hi);
        chk($sformatf("R2 lo on-time p%0d ph%0d", p, k), lo_n[k], off ? 0 : PER - exp_hi);
      end
      chk($sformatf("R2 overlap p%0d", p), ovl, 0);
      chk($sformatf("R8 fault flag p%0d", p), fbad, 0);
      chk($sformatf("R7 sat flag p%0d", p), sbad, 0);
      if (!off && ed[p-1][0] >= 2)
        chk($sformatf("R1 edge-aligned on p%0d", p), first_a + last_a, 2);
    end
    // R4: same references, link voltage doubled, applied in periods 2 and 3
    chk("R4 renormalized on-time differs", int'(ontime_a[2] != ontime_a[3]), 1);
    chk("R1 period 2 on-time", ontime_a[2], 2 * 176 - 1);
    chk("R4 period 3 on-time", ontime_a[3], 2 * 152 - 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule